// File: doc/BRIEF.md
# Flash Access Protection Gate

This block sits between an on-chip flash array and the agents that can reach it: a parallel programmer port, a serial programmer port, a CPU self-rewrite path and a test/inspection readout path. After reset it fetches a protection control byte from a fixed address in the user area, keeps it in a shadow register and decodes it into a protection level of 0 (open), 1 or 2. Every access request is then granted or refused according to its source, its operation and that level.

The control byte carries three 2-bit fields. Bits [7:6] request level 2, bits [3:2] request level 1, and bits [5:4] form an override pair that cancels protection altogether. A program request aimed at the control byte address on its own is always refused. The byte can only change through a whole-block program or erase of block 0. The flash sequencer reports the end of such an operation on `blk0_done`, and the block then fetches the byte again.

Top module: `flash_guard`

## Requirements
- R1: Within the shadow byte, bits [3:2] are the level-1 pair and bits [7:6] the level-2 pair. A pair requests its level when it differs from 2'b11. `prot_level` reports 0 for no protection, 1 for level 1 and 2 for level 2.
- R2: When the override pair, bits [5:4], equals 2'b00, `prot_level` is 0 whatever the level pairs hold.
- R3: When both levels are requested and the override pair is not 2'b00, `prot_level` is 2.
- R4: `prot_byte` returns the loaded byte with reserved bits [1:0] forced to 1, whatever was fetched for them.
- R5: After reset, `ld_req` pulses for exactly one cycle with `ld_addr` equal to the control address. The block waits for `ld_valid`, and `ready` rises one cycle after `ld_valid` is accepted. While `ready` is low, every request is refused.
- R6: A `blk0_done` pulse while ready drops `ready` one cycle later and starts a new fetch. The new byte then governs all decisions.
- R7: While `prot_level` is not 0, the parallel port is refused every operation. This also means it cannot alter the override pair. At level 0 it is served as the other rules allow.
- R8: The serial port and the CPU path are served at every protection level.
- R9: A single-byte program (op 2'b01) whose address equals the control address is refused on every source. A block program (op 2'b11) to that address is not refused by this rule.
- R10: A test-path read is refused at level 2 and served at levels 0 and 1.
- R11: Ops are encoded as 00 read, 01 program, 10 erase and 11 block program. Each request cycle produces exactly one of a grant pulse or a deny pulse on its own port, one cycle later.
- R12: In the cycle that a read is granted, the port's read data equals `fl_rdata`. In every other cycle, including every denied read, it is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | output | 1 | Fetch request for the control byte |
| ld_addr | output | AW | Address of the control byte |
| ld_valid | input | 1 | Fetched byte is valid |
| ld_data | input | 8 | Fetched control byte |
| blk0_done | input | 1 | Block 0 erase or program finished |
| fl_rdata | input | 8 | Flash array read data |
| par_req | input | 1 | Parallel port request |
| par_op | input | 2 | Parallel port operation |
| par_addr | input | AW | Parallel port address |
| par_gnt | output | 1 | Parallel port grant pulse |
| par_deny | output | 1 | Parallel port deny pulse |
| par_rdata | output | 8 | Parallel port read data |
| ser_req | input | 1 | Serial port request |
| ser_op | input | 2 | Serial port operation |
| ser_addr | input | AW | Serial port address |
| ser_gnt | output | 1 | Serial port grant pulse |
| ser_deny | output | 1 | Serial port deny pulse |
| ser_rdata | output | 8 | Serial port read data |
| cpu_req | input | 1 | CPU rewrite request |
| cpu_op | input | 2 | CPU rewrite operation |
| cpu_addr | input | AW | CPU rewrite address |
| cpu_gnt | output | 1 | CPU grant pulse |
| cpu_deny | output | 1 | CPU deny pulse |
| cpu_rdata | output | 8 | CPU read data |
| tst_req | input | 1 | Test readout request |
| tst_addr | input | AW | Test readout address |
| tst_gnt | output | 1 | Test grant pulse |
| tst_deny | output | 1 | Test deny pulse |
| tst_rdata | output | 8 | Test read data |
| ready | output | 1 | Control byte loaded and decoded |
| prot_level | output | 2 | Effective protection level |
| prot_byte | output | 8 | Shadow control byte |

## Verification
An access decision, its grant or deny pulse and any read data appear one clock after the request cycle. `ready` rises one clock after the fetched byte is accepted. It falls one clock after `blk0_done`, and `prot_byte` and `prot_level` change together with `ready`. The bench drives each stimulus on a falling edge and samples exactly one falling edge later, so every check lands in the cycle in which the result is due. The sweep reloads all 256 control byte values and tries every source, operation and address class against each of them.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int CW   = 8;
  localparam int NSRC = 4;

  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_PROG    = 2'b01,
    OP_ERASE   = 2'b10,
    OP_BLKPROG = 2'b11
  } fg_op_e;

  typedef enum logic [1:0] {
    SRC_PAR = 2'd0,
    SRC_SER = 2'd1,
    SRC_CPU = 2'd2,
    SRC_TST = 2'd3
  } fg_src_e;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_WAIT = 2'd2,
    LD_RDY  = 2'd3
  } fg_ld_e;
endpackage

// File: rtl/fg_loader.sv
module fg_loader
  import fg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk0_done,
  input  logic          ld_valid,
  input  logic [CW-1:0] ld_data,
  output logic          ld_req,
  output logic          ready,
  output logic [CW-1:0] shadow
);
  localparam logic [CW-1:0] RSV_MASK = CW'(8'h03);

  fg_ld_e        state_q, state_d;
  logic          cap_en;
  logic [CW-1:0] shadow_q;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    case (state_q)
      LD_IDLE: state_d = LD_REQ;
      LD_REQ:  state_d = LD_WAIT;
      LD_WAIT: if (ld_valid) begin
                 cap_en  = 1'b1;
                 state_d = LD_RDY;
               end
      LD_RDY:  if (blk0_done) state_d = LD_REQ;
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= '1;
    else if (cap_en) shadow_q <= ld_data | RSV_MASK;
  end

  assign ld_req = (state_q == LD_REQ);
  assign ready  = (state_q == LD_RDY);
  assign shadow = shadow_q;

  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_WAIT && ld_valid) |=> ready); // R5
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> !ld_req); // R5
  AST_RELOAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && blk0_done) |=> !ready); // R6
endmodule

// File: rtl/fg_decode.sv
module fg_decode
  import fg_pkg::*;
(
  input  logic [CW-1:2] ctrl,
  output logic [1:0]    level
);
  logic l1_req, l2_req, removed;

  always_comb begin
    l1_req  = (ctrl[3:2] != 2'b11);
    l2_req  = (ctrl[7:6] != 2'b11);
    removed = (ctrl[5:4] == 2'b00);
    if (removed)     level = 2'd0;
    else if (l2_req) level = 2'd2;
    else if (l1_req) level = 2'd1;
    else             level = 2'd0;
  end
endmodule

// File: rtl/fg_gate.sv
module fg_gate
  import fg_pkg::*;
#(
  parameter int              AW        = 16,
  parameter logic [AW-1:0]   CTRL_ADDR = '1,
  parameter fg_src_e         KIND      = SRC_PAR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic [1:0]    level,
  input  logic          req,
  input  fg_op_e        op,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] fl_rdata,
  output logic          gnt,
  output logic          deny,
  output logic [CW-1:0] rdata
);
  logic policy_ok, ctrl_hit, allow;
  logic gnt_d, deny_d, rd_d;
  logic gnt_q, deny_q, rd_q;

  always_comb begin
    case (KIND)
      SRC_PAR: policy_ok = (level == 2'd0);
      SRC_TST: policy_ok = (level != 2'd2) && (op == OP_READ);
      default: policy_ok = 1'b1;
    endcase
    ctrl_hit = (op == OP_PROG) && (addr == CTRL_ADDR);
    allow    = ready && policy_ok && !ctrl_hit;
    gnt_d    = req && allow;
    deny_d   = req && !allow;
    rd_d     = (op == OP_READ);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= 1'b0;
      deny_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      deny_q <= deny_d;
      rd_q   <= rd_d;
    end
  end

  assign gnt   = gnt_q;
  assign deny  = deny_q;
  assign rdata = (gnt_q && rd_q) ? fl_rdata : '1;

  AST_NOT_READY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ready) |=> deny); // R5
  AST_PAR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == SRC_PAR && req && level != 2'd0) |=> (deny && !gnt)); // R7
  AST_CTRL_PROG_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && op == OP_PROG && addr == CTRL_ADDR) |=> deny); // R9
  AST_TST_L2_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (KIND == SRC_TST && req && level == 2'd2) |=> deny); // R10
  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (gnt ^ deny)); // R11
  AST_DENY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> (rdata == '1)); // R12
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int            AW        = 16,
  parameter logic [AW-1:0] CTRL_ADDR = 16'hFFDB
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          ld_req,
  output logic [AW-1:0] ld_addr,
  input  logic          ld_valid,
  input  logic [7:0]    ld_data,
  input  logic          blk0_done,
  input  logic [7:0]    fl_rdata,
  input  logic          par_req,
  input  logic [1:0]    par_op,
  input  logic [AW-1:0] par_addr,
  output logic          par_gnt,
  output logic          par_deny,
  output logic [7:0]    par_rdata,
  input  logic          ser_req,
  input  logic [1:0]    ser_op,
  input  logic [AW-1:0] ser_addr,
  output logic          ser_gnt,
  output logic          ser_deny,
  output logic [7:0]    ser_rdata,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_op,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_gnt,
  output logic          cpu_deny,
  output logic [7:0]    cpu_rdata,
  input  logic          tst_req,
  input  logic [AW-1:0] tst_addr,
  output logic          tst_gnt,
  output logic          tst_deny,
  output logic [7:0]    tst_rdata,
  output logic          ready,
  output logic [1:0]    prot_level,
  output logic [7:0]    prot_byte
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [CW-1:0]   shadow;
  logic [NSRC-1:0] req_a, gnt_a, deny_a;
  logic [1:0]      op_a   [NSRC];
  logic [AW-1:0]   addr_a [NSRC];
  logic [CW-1:0]   rd_a   [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fg_loader u_loader (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .blk0_done (blk0_done),
    .ld_valid  (ld_valid),
    .ld_data   (ld_data),
    .ld_req    (ld_req),
    .ready     (ready),
    .shadow    (shadow)
  );
  assign ld_addr = CTRL_ADDR;

  fg_decode u_decode (
    .ctrl  (shadow[CW-1:2]),
    .level (prot_level)
  );
  assign prot_byte = shadow;

  assign req_a  = {tst_req, cpu_req, ser_req, par_req};
  assign op_a   = '{par_op, ser_op, cpu_op, OP_READ};
  assign addr_a = '{par_addr, ser_addr, cpu_addr, tst_addr};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    fg_gate #(
      .AW        (AW),
      .CTRL_ADDR (CTRL_ADDR),
      .KIND      (fg_src_e'(i))
    ) u_gate (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .ready    (ready),
      .level    (prot_level),
      .req      (req_a[i]),
      .op       (fg_op_e'(op_a[i])),
      .addr     (addr_a[i]),
      .fl_rdata (fl_rdata),
      .gnt      (gnt_a[i]),
      .deny     (deny_a[i]),
      .rdata    (rd_a[i])
    );
  end

  assign par_gnt = gnt_a[0]; assign par_deny = deny_a[0]; assign par_rdata = rd_a[0];
  assign ser_gnt = gnt_a[1]; assign ser_deny = deny_a[1]; assign ser_rdata = rd_a[1];
  assign cpu_gnt = gnt_a[2]; assign cpu_deny = deny_a[2]; assign cpu_rdata = rd_a[2];
  assign tst_gnt = gnt_a[3]; assign tst_deny = deny_a[3]; assign tst_rdata = rd_a[3];

  AST_OVERRIDE_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ready && prot_byte[5:4] == 2'b00) |-> (prot_level == 2'd0)); // R2
  AST_L2_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ready && prot_byte[5:4] != 2'b00 && prot_byte[7:6] != 2'b11) |-> (prot_level == 2'd2)); // R3
  AST_RSV_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    ready |-> (prot_byte[1:0] == 2'b11)); // R4
endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  localparam int            AW   = 16;
  localparam logic [AW-1:0] CTRL = 16'hFFDB;
  localparam logic [AW-1:0] OTHR = 16'h1234;
  localparam logic [7:0]    FDAT = 8'h5A;

  logic clk, rst_n;
  logic ld_req, ld_valid, blk0_done;
  logic [AW-1:0] ld_addr;
  logic [7:0] ld_data;
  logic par_req, ser_req, cpu_req, tst_req;
  logic [1:0] par_op, ser_op, cpu_op;
  logic [AW-1:0] par_addr, ser_addr, cpu_addr, tst_addr;
  logic par_gnt, par_deny, ser_gnt, ser_deny, cpu_gnt, cpu_deny, tst_gnt, tst_deny;
  logic [7:0] par_rdata, ser_rdata, cpu_rdata, tst_rdata;
  logic ready;
  logic [1:0] prot_level;
  logic [7:0] prot_byte;

  int checks = 0;
  int fails  = 0;

  flash_guard #(.AW(AW), .CTRL_ADDR(CTRL)) dut (
    .clk(clk), .rst_n(rst_n),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_valid(ld_valid), .ld_data(ld_data),
    .blk0_done(blk0_done), .fl_rdata(FDAT),
    .par_req(par_req), .par_op(par_op), .par_addr(par_addr),
    .par_gnt(par_gnt), .par_deny(par_deny), .par_rdata(par_rdata),
    .ser_req(ser_req), .ser_op(ser_op), .ser_addr(ser_addr),
    .ser_gnt(ser_gnt), .ser_deny(ser_deny), .ser_rdata(ser_rdata),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_gnt(cpu_gnt), .cpu_deny(cpu_deny), .cpu_rdata(cpu_rdata),
    .tst_req(tst_req), .tst_addr(tst_addr),
    .tst_gnt(tst_gnt), .tst_deny(tst_deny), .tst_rdata(tst_rdata),
    .ready(ready), .prot_level(prot_level), .prot_byte(prot_byte)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_level(logic [7:0] b);
    if (b[5:4] == 2'b00)  return 2'd0;
    if (b[7:6] != 2'b11)  return 2'd2;
    if (b[3:2] != 2'b11)  return 2'd1;
    return 2'd0;
  endfunction

  task automatic drive(int src, logic v, logic [1:0] op, logic [AW-1:0] a);
    case (src)
      0: begin par_req = v; par_op = op; par_addr = a; end
      1: begin ser_req = v; ser_op = op; ser_addr = a; end
      2: begin cpu_req = v; cpu_op = op; cpu_addr = a; end
      default: begin tst_req = v; tst_addr = a; end
    endcase
  endtask

  task automatic access(int src, logic [1:0] op, logic [AW-1:0] a, logic rdy, logic [1:0] lvl);
    logic g, d, allow, pol;
    logic [7:0] rd;
    string tag;
    @(negedge clk);
    drive(src, 1'b1, op, a);
    @(negedge clk);
    case (src)
      0: begin g = par_gnt; d = par_deny; rd = par_rdata; end
      1: begin g = ser_gnt; d = ser_deny; rd = ser_rdata; end
      2: begin g = cpu_gnt; d = cpu_deny; rd = cpu_rdata; end
      default: begin g = tst_gnt; d = tst_deny; rd = tst_rdata; end
    endcase
    drive(src, 1'b0, 2'b00, '0);
    pol   = (src == 0) ? (lvl == 2'd0) : (src == 3) ? (lvl != 2'd2) : 1'b1;
    allow = rdy && pol && !(op == 2'b01 && a == CTRL);
    if (!rdy)                       tag = "R5";
    else if (op == 2'b01 && a == CTRL) tag = "R9";
    else if (src == 0)              tag = "R7";
    else if (src == 3)              tag = "R10";
    else                            tag = "R8";
    check({tag, " grant"}, {31'd0, g}, {31'd0, allow});
    check("R11 deny", {31'd0, d}, {31'd0, !allow});
    check("R12 rdata", {24'd0, rd}, {24'd0, (allow && op == 2'b00) ? FDAT : 8'hFF});
  endtask

  task automatic load(logic [7:0] b, logic first);
    logic [1:0] exp;
    if (!first) begin
      @(negedge clk);
      blk0_done = 1'b1;
      @(negedge clk);
      blk0_done = 1'b0;
      check("R6 ready drop", {31'd0, ready}, 32'd0);
    end
    while (ld_req !== 1'b1) @(negedge clk);
    check("R5 ld_addr", {16'd0, ld_addr}, {16'd0, CTRL});
    @(negedge clk);
    check("R5 ld_req pulse", {31'd0, ld_req}, 32'd0);
    if (first) begin
      @(negedge clk);
      par_req = 1'b1; par_op = 2'b00; par_addr = OTHR;
      @(negedge clk);
      check("R5 deny before ready", {31'd0, par_deny}, 32'd1);
      par_req = 1'b0;
    end
    ld_valid = 1'b1;
    ld_data  = b;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R5 ready", {31'd0, ready}, 32'd1);
    check("R4 prot_byte", {24'd0, prot_byte}, {24'd0, b | 8'h03});
    exp = model_level(b);
    if (b[5:4] == 2'b00)
      check("R2 level", {30'd0, prot_level}, {30'd0, exp});
    else if (b[7:6] != 2'b11 && b[3:2] != 2'b11)
      check("R3 level", {30'd0, prot_level}, {30'd0, exp});
    else
      check("R1 level", {30'd0, prot_level}, {30'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; ld_data = '0; blk0_done = 1'b0;
    par_req = 0; ser_req = 0; cpu_req = 0; tst_req = 0;
    par_op = 0; ser_op = 0; cpu_op = 0;
    par_addr = '0; ser_addr = '0; cpu_addr = '0; tst_addr = '0;
    repeat (3) @(negedge clk);
    check("R5 reset ready", {31'd0, ready}, 32'd0);
    check("R11 reset gnt", {28'd0, par_gnt, ser_gnt, cpu_gnt, tst_gnt}, 32'd0);
    check("R12 reset rdata", {24'd0, par_rdata}, 32'hFF);
    rst_n = 1'b1;
    load(8'hFF, 1'b1);
    for (int b = 0; b < 256; b++) begin
      load(8'(b), 1'b0);
      for (int s = 0; s < 4; s++) begin
        for (int o = 0; o < 4; o++) begin
          if (s == 3 && o != 0) continue;
          access(s, 2'(o), CTRL, 1'b1, model_level(8'(b)));
          access(s, 2'(o), OTHR, 1'b1, model_level(8'(b)));
        end
      end
      @(negedge clk);
      check("R11 pulse ends", {31'd0, par_deny | par_gnt}, 32'd0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule